// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block merges three reasons for holding a processor in reset into a single reset pin. The three reasons are a power-on event, a supply that has dropped below its safe level, and a watchdog that was not serviced in time. The supply indication comes from an external comparator and is already synchronised to the block clock. The power-on event is the block's synchronous reset input. The watchdog is serviced through the same pin that serves as the serial-bus chip select, so ordinary bus traffic keeps the watchdog quiet. A falling transition on that pin restarts the watchdog count.

The watchdog interval comes from a two-bit select held in a retained configuration register outside the block. Three codes pick one of three tick counts set by parameters. The fourth code switches the watchdog off. A volatile cause bit tells software whether the most recent reset came from the watchdog. A write strobe from the status register clears it. A parameter selects whether the reset pin is active low or active high. All lengths are counted in clock ticks, so a simulation can use short values.

Top module: `wdt_reset_sup`

## Requirements
- R1: While `rst` is high, the reset pin is asserted. After `rst` falls, the pin stays asserted and is released on the POR_TICKS-th rising clock edge after the last edge that sampled `rst` high.
- R2: A rising edge that samples `supply_low` high asserts the reset pin. The pin is released on the LOW_TICKS-th rising edge after the last edge that sampled `supply_low` high.
- R3: `wd_sel` codes 0, 1 and 2 select intervals of WD_TICKS0, WD_TICKS1 and WD_TICKS2. With no service, the reset pin asserts on the interval-th rising edge after the edge that released it.
- R4: A falling transition on `cs_wdi` passes through two synchroniser flops and clears the watchdog count on the third rising edge after the pin falls. Expiry then comes the interval-th edge after that clearing edge. Rising transitions and steady levels do not restart the count.
- R5: `wd_sel` code 3 disables the watchdog, and the reset pin is then never asserted by it. The count is held at zero while disabled, so a later enable starts a full interval.
- R6: A watchdog reset lasts POR_TICKS edges. The watchdog count is held clear while the reset pin is asserted, so each release is followed by a full interval.
- R7: `wd_cause` is 1 from the edge on which a watchdog reset begins. It is cleared by `rst`, by `supply_low`, and by a `flag_clr` pulse. When a watchdog expiry falls on the same edge as `flag_clr`, the expiry wins.
- R8: With RST_ACTIVE_HIGH = 0, the reset pin is low while asserted. With RST_ACTIVE_HIGH = 1, it is high while asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on event |
| supply_low | input | 1 | Synchronised supply-below-threshold indication |
| cs_wdi | input | 1 | Shared chip-select / watchdog service pin, asynchronous |
| wd_sel | input | 2 | Retained watchdog interval select (3 = off) |
| flag_clr | input | 1 | Status write strobe that clears the cause bit |
| rst_pin | output | 1 | Reset output, polarity set by RST_ACTIVE_HIGH |
| wd_cause | output | 1 | 1 when the last reset came from the watchdog |

## Verification
A watchdog count that is wrong or stuck shows up at the pin as a reset that comes too early or too late. The error is visible within one interval after a release or a service edge. The tests therefore measure the exact edge of every assertion and release. An error in the hold counter changes the measured pulse length on the very next power-on, supply or watchdog event. A cause bit with the wrong set/clear priority is visible on `wd_cause` one edge after the colliding events.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    WD_SEL_SHORT = 2'd0,
    WD_SEL_MID   = 2'd1,
    WD_SEL_LONG  = 2'd2,
    WD_SEL_OFF   = 2'd3
  } wd_sel_e;

  function automatic int max_of2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int max_of3(input int a, input int b, input int c);
    return max_of2(max_of2(a, b), c);
  endfunction

endpackage

// File: rtl/sup_kick_detect.sv
// Synchronises the shared chip-select pin and emits a one-cycle pulse
// on each falling transition of the synchronised level.
module sup_kick_detect #(
  parameter int SYNC_STAGES = 2,
  parameter bit IDLE_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic kick
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   last_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain    <= {SYNC_STAGES{IDLE_LEVEL}};
      last_lvl <= IDLE_LEVEL;
    end else begin
      chain[0] <= pin_async;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
      last_lvl <= chain[TOP];
    end
  end

  assign kick = last_lvl & ~chain[TOP];

endmodule

// File: rtl/sup_wd_timer.sv
// Watchdog interval counter with three selectable limits and an off code.
module sup_wd_timer
  import sup_pkg::*;
#(
  parameter int WD_TICKS0 = 50,
  parameter int WD_TICKS1 = 100,
  parameter int WD_TICKS2 = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       kick,
  input  logic [1:0] sel,
  output logic       expire
);

  localparam int TMAX = max_of3(WD_TICKS0, WD_TICKS1, WD_TICKS2);
  localparam int CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          run;

  always_comb begin
    unique case (wd_sel_e'(sel))
      WD_SEL_SHORT: limit = CW'(WD_TICKS0 - 1);
      WD_SEL_MID:   limit = CW'(WD_TICKS1 - 1);
      WD_SEL_LONG:  limit = CW'(WD_TICKS2 - 1);
      default:      limit = '0;
    endcase
  end

  assign run    = (wd_sel_e'(sel) != WD_SEL_OFF) && !hold;
  assign expire = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run || kick || expire) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sup_rst_hold.sv
// Reset stretcher: loads a hold length on each reset event and releases
// when the hold count runs out.
module sup_rst_hold
  import sup_pkg::*;
#(
  parameter int POR_TICKS = 16,
  parameter int LOW_TICKS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic wd_expire,
  output logic active
);

  localparam int HMAX = max_of2(POR_TICKS, LOW_TICKS);
  localparam int HW   = $clog2(HMAX + 1);

  logic [HW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      left   <= HW'(POR_TICKS - 1);
    end else if (supply_low) begin
      active <= 1'b1;
      left   <= HW'(LOW_TICKS - 1);
    end else if (wd_expire) begin
      active <= 1'b1;
      left   <= HW'(POR_TICKS - 1);
    end else if (active) begin
      if (left == '0) begin
        active <= 1'b0;
      end else begin
        left <= left - 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdt_reset_sup.sv
module wdt_reset_sup #(
  parameter int POR_TICKS       = 16,
  parameter int LOW_TICKS       = 12,
  parameter int WD_TICKS0       = 50,
  parameter int WD_TICKS1       = 100,
  parameter int WD_TICKS2       = 200,
  parameter int SYNC_STAGES     = 2,
  parameter bit RST_ACTIVE_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_low,
  input  logic       cs_wdi,
  input  logic [1:0] wd_sel,
  input  logic       flag_clr,
  output logic       rst_pin,
  output logic       wd_cause
);

  logic kick;
  logic wd_expire;
  logic hold_active;

  sup_kick_detect #(
    .SYNC_STAGES (SYNC_STAGES),
    .IDLE_LEVEL  (1'b1)
  ) u_kick (
    .clk       (clk),
    .rst       (rst),
    .pin_async (cs_wdi),
    .kick      (kick)
  );

  sup_wd_timer #(
    .WD_TICKS0 (WD_TICKS0),
    .WD_TICKS1 (WD_TICKS1),
    .WD_TICKS2 (WD_TICKS2)
  ) u_wd (
    .clk    (clk),
    .rst    (rst),
    .hold   (hold_active),
    .kick   (kick),
    .sel    (wd_sel),
    .expire (wd_expire)
  );

  sup_rst_hold #(
    .POR_TICKS (POR_TICKS),
    .LOW_TICKS (LOW_TICKS)
  ) u_hold (
    .clk        (clk),
    .rst        (rst),
    .supply_low (supply_low),
    .wd_expire  (wd_expire),
    .active     (hold_active)
  );

  // Cause bit: supply and power-on clear it, expiry sets it ahead of a
  // software clear on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      wd_cause <= 1'b0;
    end else if (supply_low) begin
      wd_cause <= 1'b0;
    end else if (wd_expire) begin
      wd_cause <= 1'b1;
    end else if (flag_clr) begin
      wd_cause <= 1'b0;
    end
  end

  generate
    if (RST_ACTIVE_HIGH) begin : g_pol_high
      assign rst_pin = hold_active;
    end else begin : g_pol_low
      assign rst_pin = ~hold_active;
    end
  endgenerate

endmodule

// File: rtl/sup_checker.sv
module sup_checker (
  input logic       clk,
  input logic       rst,
  input logic       supply_low,
  input logic       flag_clr,
  input logic [1:0] wd_sel,
  input logic       kick,
  input logic       wd_expire,
  input logic       hold_active,
  input logic       wd_cause
);

  // R2: a sampled supply-low holds reset on the next cycle
  p_low_holds_r2: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> hold_active);

  // R4: a detected service edge is a single-cycle pulse
  p_kick_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    kick |=> !kick);

  // R5: the off code never produces an expiry
  p_off_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (wd_sel == 2'd3) |-> !wd_expire);

  // R6: no expiry while reset is held
  p_no_expire_in_hold_r6: assert property (@(posedge clk) disable iff (rst)
    hold_active |-> !wd_expire);

  // R6 / R7: an expiry starts a reset and marks the cause
  p_expire_resets_r7: assert property (@(posedge clk) disable iff (rst)
    (wd_expire && !supply_low) |=> (hold_active && wd_cause));

  // R7: the cause bit only rises after an expiry
  p_cause_source_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_cause) |-> $past(wd_expire));

  // R7: a clear without a colliding expiry drops the cause bit
  p_clear_works_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !wd_expire) |=> !wd_cause);

  // R2: release never follows an edge that saw supply low
  p_release_clean_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_active) |-> !$past(supply_low));

endmodule

bind wdt_reset_sup sup_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .supply_low  (supply_low),
  .flag_clr    (flag_clr),
  .wd_sel      (wd_sel),
  .kick        (kick),
  .wd_expire   (wd_expire),
  .hold_active (hold_active),
  .wd_cause    (wd_cause)
);

// File: tb/sim_wdt_reset_sup.sv
module sim_wdt_reset_sup;

  localparam int CLK_PERIOD = 10;
  localparam int POR = 8;
  localparam int LOW = 5;
  localparam int W0  = 20;
  localparam int W1  = 40;
  localparam int W2  = 70;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_low = 1'b0;
  logic       cs_wdi = 1'b1;
  logic       flag_clr = 1'b0;
  logic [1:0] wd_sel = 2'd0;
  logic       pin_lo, pin_hi, cause_lo, cause_hi;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_reset_sup #(.POR_TICKS(POR), .LOW_TICKS(LOW), .WD_TICKS0(W0),
    .WD_TICKS1(W1), .WD_TICKS2(W2), .RST_ACTIVE_HIGH(1'b0)) u0 (
    .clk(clk), .rst(rst), .supply_low(supply_low), .cs_wdi(cs_wdi),
    .wd_sel(wd_sel), .flag_clr(flag_clr), .rst_pin(pin_lo), .wd_cause(cause_lo));

  wdt_reset_sup #(.POR_TICKS(POR), .LOW_TICKS(LOW), .WD_TICKS0(W0),
    .WD_TICKS1(W1), .WD_TICKS2(W2), .RST_ACTIVE_HIGH(1'b1)) u1 (
    .clk(clk), .rst(rst), .supply_low(supply_low), .cs_wdi(cs_wdi),
    .wd_sel(wd_sel), .flag_clr(flag_clr), .rst_pin(pin_hi), .wd_cause(cause_hi));

  function automatic bit in_reset();
    return (pin_lo == 1'b0);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // counts rising edges until the reset state equals want (sampled at negedge)
  task automatic wait_state(input bit want, input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (in_reset() != want && n < limit);
  endtask

  task automatic power_cycle(output int n);
    @(negedge clk);
    rst = 1'b1;
    flag_clr = 1'b0;
    supply_low = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_state(1'b0, 1000, n);
  endtask

  task automatic t_power_on();
    int n;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(in_reset(), "R1 pin asserted during rst", pin_lo, 0);
    check(pin_hi == 1'b1, "R8 active-high pin during rst", pin_hi, 1);
    check(cause_lo == 1'b0, "R7 cause cleared by rst", cause_lo, 0);
    rst = 1'b0;
    wait_state(1'b0, 1000, n);
    check(n == POR, "R1 release edge", n, POR);
    check(pin_hi == 1'b0, "R8 active-high pin released", pin_hi, 0);
  endtask

  task automatic t_supply();
    int n;
    wd_sel = 2'd3;
    power_cycle(n);
    @(negedge clk);
    supply_low = 1'b1;
    @(negedge clk);
    check(in_reset(), "R2 asserted on supply low", pin_lo, 0);
    check(pin_hi == 1'b1, "R8 active-high during supply low", pin_hi, 1);
    repeat (6) @(negedge clk);
    check(in_reset(), "R2 held while supply low", pin_lo, 0);
    supply_low = 1'b0;
    wait_state(1'b0, 1000, n);
    check(n == LOW, "R2 stabilisation length", n, LOW);
  endtask

  task automatic t_interval(input logic [1:0] sel, input int len);
    int n;
    wd_sel = sel;
    power_cycle(n);
    wait_state(1'b1, len + 50, n);
    check(n == len, "R3 watchdog interval", n, len);
    check(cause_lo == 1'b1, "R7 cause set on expiry", cause_lo, 1);
    wait_state(1'b0, 1000, n);
    check(n == POR, "R6 watchdog pulse length", n, POR);
    wait_state(1'b1, len + 50, n);
    check(n == len, "R6 full interval after release", n, len);
  endtask

  task automatic t_kick();
    int n;
    int hits;
    wd_sel = 2'd0;
    cs_wdi = 1'b1;
    power_cycle(n);
    hits = 0;
    for (int k = 0; k < 6; k++) begin
      cs_wdi = 1'b0;
      repeat (4) begin @(negedge clk); if (in_reset()) hits++; end
      cs_wdi = 1'b1;
      repeat (8) begin @(negedge clk); if (in_reset()) hits++; end
    end
    check(hits == 0, "R4 regular service prevents reset", hits, 0);
    cs_wdi = 1'b0;
    wait_state(1'b1, W0 + 50, n);
    check(n == W0 + 3, "R4 expiry after last service edge", n, W0 + 3);
    cs_wdi = 1'b1;
  endtask

  task automatic t_rise_only();
    int n;
    wd_sel = 2'd0;
    cs_wdi = 1'b0;
    power_cycle(n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 5) cs_wdi = 1'b1;
    end while (!in_reset() && n < W0 + 50);
    check(n == W0, "R4 rising edge does not restart", n, W0);
  endtask

  task automatic t_disabled();
    int n;
    int hits;
    wd_sel = 2'd3;
    power_cycle(n);
    hits = 0;
    repeat (3 * W2) begin @(negedge clk); if (in_reset()) hits++; end
    check(hits == 0, "R5 off code never resets", hits, 0);
    wd_sel = 2'd0;
    wait_state(1'b1, W0 + 50, n);
    check(n == W0, "R5 full interval after enable", n, W0);
  endtask

  task automatic t_flag();
    int n;
    wd_sel = 2'd0;
    power_cycle(n);
    wait_state(1'b1, W0 + 50, n);
    wait_state(1'b0, 1000, n);
    check(cause_lo == 1'b1, "R7 cause kept after release", cause_lo, 1);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check(cause_lo == 1'b0, "R7 status write clears", cause_lo, 0);
    repeat (W0 - 3) @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check(cause_lo == 1'b1, "R7 expiry wins over clear", cause_lo, 1);
    check(in_reset(), "R7 expiry edge asserts reset", pin_lo, 0);
    @(negedge clk);
    supply_low = 1'b1;
    @(negedge clk);
    supply_low = 1'b0;
    check(cause_lo == 1'b0, "R7 supply low clears", cause_lo, 0);
    wait_state(1'b0, 1000, n);
    check(n == LOW, "R2 supply low during watchdog reset", n, LOW);
    wait_state(1'b1, W0 + 50, n);
    check(cause_lo == 1'b1, "R7 set again", cause_lo, 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(cause_lo == 1'b0, "R7 rst clears cause", cause_lo, 0);
    rst = 1'b0;
    wait_state(1'b0, 1000, n);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_power_on();
    t_supply();
    t_interval(2'd0, W0);
    t_interval(2'd1, W1);
    t_interval(2'd2, W2);
    t_kick();
    t_rise_only();
    t_disabled();
    t_flag();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule